// File: doc/BRIEF.md
# Boot Vector and Fetch Range Guard

This block supervises start-up and instruction fetch for a small 16-bit microcontroller core. As soon as reset is released, it keeps the core stalled and issues two word reads on a valid/ready memory port. The first read fetches the reset vector and the second fetches the loader security key. When the key response arrives, the block releases the stall. If the reset vector holds the erased-flash pattern 16'hFFFF, it puts the core into its deepest sleep mode. Otherwise it lets the core run. It decodes the key word into two loader-control flags and holds them until the next reset.

While the core runs, the block watches every instruction fetch. A fetch from the peripheral register window 16'h0000..16'h01FF is illegal. A fetch flagged as unmapped by the external address-valid map is also illegal. Either one raises a reset request that stays high for a fixed number of cycles.

The request channel follows valid/ready rules. `rd_req_valid` and `rd_addr` stay asserted and unchanged until a cycle in which `rd_req_ready` is high. That cycle is the handshake. The response channel has no back-pressure from the memory side. `rd_rsp_ready` is high only while the block waits for data. A response is taken in a cycle where both `rd_rsp_valid` and `rd_rsp_ready` are high.

Top module: `boot_guard`

## Requirements
- R1: From reset release until the key response is accepted, `cpu_stall`=1, `core_run`=0 and `core_sleep`=0. During this time `ldr_disable`=1 and `bad_pw_erase_en`=0. The first request presents `rd_addr`=16'hFFFE with `rd_req_valid`=1.
- R2: A pending request keeps `rd_req_valid` high and `rd_addr` stable until the handshake. After the vector response, exactly one more request is made, to 16'hFFDE.
- R3: A reset vector of 16'hFFFF gives `core_sleep`=1 and `core_run`=0. Any other vector gives `core_run`=1 and `core_sleep`=0.
- R4: In the cycle `cpu_stall` falls, exactly one of `core_run` or `core_sleep` rises. That decision holds until reset, and no further read requests are made.
- R5: A key word of 16'hAA55 gives `ldr_disable`=1 and `bad_pw_erase_en`=1. The flags stay fixed until the next reset.
- R6: A key word of 16'h0000 gives `ldr_disable`=0 and `bad_pw_erase_en`=0.
- R7: Any other key word gives `ldr_disable`=0 and `bad_pw_erase_en`=1.
- R8: While running, a fetch with an address in 16'h0000..16'h01FF raises `rst_req`, even when `fetch_mapped`=1.
- R9: While running, a fetch with `fetch_mapped`=0 raises `rst_req`.
- R10: While running, a fetch from 16'h0200..16'hFFFF with `fetch_mapped`=1 leaves `rst_req` low. This includes the unused vector words 16'hFFC0..16'hFFDC.
- R11: `rst_req` rises in the cycle after an illegal fetch is sampled. For an isolated fetch it stays high for exactly RST_HOLD cycles (default 8). A further illegal fetch while it is high reloads the count.
- R12: Fetches are ignored while the core is stalled or sleeping, so `rst_req` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rd_req_valid | output | 1 | Read request valid |
| rd_req_ready | input | 1 | Memory accepts the request |
| rd_addr | output | 16 | Word address of the read |
| rd_rsp_valid | input | 1 | Read data valid |
| rd_rsp_data | input | 16 | Read data |
| rd_rsp_ready | output | 1 | Block is waiting for read data |
| fetch_valid | input | 1 | Instruction fetch strobe |
| fetch_addr | input | 16 | Instruction fetch address |
| fetch_mapped | input | 1 | Fetch address lies in implemented memory |
| cpu_stall | output | 1 | Hold the core; start-up decision pending |
| core_run | output | 1 | Core may execute |
| core_sleep | output | 1 | Core enters deepest low-power mode |
| rst_req | output | 1 | Reset request after an illegal fetch |
| ldr_disable | output | 1 | Bootstrap loader is switched off |
| bad_pw_erase_en | output | 1 | A wrong loader password triggers mass erase |

## Verification
The assertions assume the memory side sends exactly one response per accepted request, and only while `rd_rsp_ready` is high. They also assume `fetch_mapped` is meaningful only together with `fetch_valid`. The bench's responder honours these rules. It starts a transfer only after it sees a request. It may withhold ready for a few cycles. It then answers once after a chosen latency. The fetch sweep pairs addresses with arbitrary map bits. It applies fetches both during the stalled start-up window and in the sleeping state, where they must have no effect.

// File: rtl/boot_guard_pkg.sv
package boot_guard_pkg;
  localparam int unsigned WORD_W = 16;
  localparam logic [WORD_W-1:0] RESET_VEC_ADDR = 16'hFFFE;
  localparam logic [WORD_W-1:0] KEY_WORD_ADDR  = 16'hFFDE;
  localparam logic [WORD_W-1:0] ERASED_WORD    = 16'hFFFF;
  localparam logic [WORD_W-1:0] KEY_LOADER_OFF = 16'hAA55;
  localparam logic [WORD_W-1:0] KEY_KEEP_FLASH = 16'h0000;
  localparam logic [WORD_W-1:0] PERIPH_LAST    = 16'h01FF;

  typedef enum logic [2:0] {
    SEQ_ASK_VEC,
    SEQ_GET_VEC,
    SEQ_ASK_KEY,
    SEQ_GET_KEY,
    SEQ_DONE
  } seq_state_e;
endpackage

// File: rtl/bg_boot_seq.sv
module bg_boot_seq
  import boot_guard_pkg::*;
#(
  parameter int unsigned AW = 16,
  parameter int unsigned DW = 16,
  parameter logic [AW-1:0] VEC_ADDR = RESET_VEC_ADDR,
  parameter logic [AW-1:0] KEY_ADDR = KEY_WORD_ADDR,
  parameter logic [DW-1:0] BLANK    = ERASED_WORD
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic          req_valid,
  input  logic          req_ready,
  output logic [AW-1:0] req_addr,
  input  logic          rsp_valid,
  input  logic [DW-1:0] rsp_data,
  output logic          rsp_ready,
  output logic          key_load,
  output logic [DW-1:0] key_data,
  output logic          done,
  output logic          blank
);
  seq_state_e state, state_nx;
  logic       blank_q;
  logic       take;

  always_comb begin
    req_valid = (state == SEQ_ASK_VEC) || (state == SEQ_ASK_KEY);
    req_addr  = (state == SEQ_ASK_KEY) ? KEY_ADDR : VEC_ADDR;
    rsp_ready = (state == SEQ_GET_VEC) || (state == SEQ_GET_KEY);
    take      = rsp_ready && rsp_valid;
    key_load  = take && (state == SEQ_GET_KEY);
    key_data  = rsp_data;
    done      = (state == SEQ_DONE);
    blank     = blank_q;
  end

  always_comb begin
    state_nx = state;
    case (state)
      SEQ_ASK_VEC: if (req_ready) state_nx = SEQ_GET_VEC;
      SEQ_GET_VEC: if (take)      state_nx = SEQ_ASK_KEY;
      SEQ_ASK_KEY: if (req_ready) state_nx = SEQ_GET_KEY;
      SEQ_GET_KEY: if (take)      state_nx = SEQ_DONE;
      default:                    state_nx = SEQ_DONE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= SEQ_ASK_VEC;
      blank_q <= 1'b0;
    end else begin
      state <= state_nx;
      if (take && (state == SEQ_GET_VEC)) blank_q <= (rsp_data == BLANK);
    end
  end
endmodule

// File: rtl/bg_key_decode.sv
module bg_key_decode
  import boot_guard_pkg::*;
#(
  parameter int unsigned DW = 16,
  parameter logic [DW-1:0] OFF_KEY  = KEY_LOADER_OFF,
  parameter logic [DW-1:0] KEEP_KEY = KEY_KEEP_FLASH
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] key,
  output logic          ldr_off,
  output logic          erase_en
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ldr_off  <= 1'b1;
      erase_en <= 1'b0;
    end else if (load) begin
      ldr_off  <= (key == OFF_KEY);
      erase_en <= (key != KEEP_KEY);
    end
  end
endmodule

// File: rtl/bg_fetch_guard.sv
module bg_fetch_guard
  import boot_guard_pkg::*;
#(
  parameter int unsigned AW = 16,
  parameter logic [AW-1:0] LAST_PERIPH = PERIPH_LAST,
  parameter int unsigned HOLD = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          armed,
  input  logic          fetch_valid,
  input  logic [AW-1:0] fetch_addr,
  input  logic          fetch_mapped,
  output logic          rst_req
);
  localparam int unsigned CW = $clog2(HOLD + 1);

  logic [CW-1:0] cnt;
  logic          in_periph;
  logic          illegal;

  always_comb begin
    in_periph = (fetch_addr <= LAST_PERIPH);
    illegal   = armed && fetch_valid && (in_periph || !fetch_mapped);
    rst_req   = (cnt != '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (illegal)      cnt <= CW'(HOLD);
    else if (cnt != '0)    cnt <= cnt - CW'(1);
  end
endmodule

// File: rtl/boot_guard.sv
module boot_guard
  import boot_guard_pkg::*;
#(
  parameter int unsigned RST_HOLD = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic              rd_req_valid,
  input  logic              rd_req_ready,
  output logic [WORD_W-1:0] rd_addr,
  input  logic              rd_rsp_valid,
  input  logic [WORD_W-1:0] rd_rsp_data,
  output logic              rd_rsp_ready,
  input  logic              fetch_valid,
  input  logic [WORD_W-1:0] fetch_addr,
  input  logic              fetch_mapped,
  output logic              cpu_stall,
  output logic              core_run,
  output logic              core_sleep,
  output logic              rst_req,
  output logic              ldr_disable,
  output logic              bad_pw_erase_en
);
  logic              seq_done;
  logic              seq_blank;
  logic              key_load;
  logic [WORD_W-1:0] key_data;

  bg_boot_seq #(.AW(WORD_W), .DW(WORD_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (rd_req_valid),
    .req_ready (rd_req_ready),
    .req_addr  (rd_addr),
    .rsp_valid (rd_rsp_valid),
    .rsp_data  (rd_rsp_data),
    .rsp_ready (rd_rsp_ready),
    .key_load  (key_load),
    .key_data  (key_data),
    .done      (seq_done),
    .blank     (seq_blank)
  );

  bg_key_decode #(.DW(WORD_W)) u_key (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (key_load),
    .key      (key_data),
    .ldr_off  (ldr_disable),
    .erase_en (bad_pw_erase_en)
  );

  always_comb begin
    cpu_stall  = !seq_done;
    core_run   = seq_done && !seq_blank;
    core_sleep = seq_done && seq_blank;
  end

  bg_fetch_guard #(.AW(WORD_W), .HOLD(RST_HOLD)) u_fetch (
    .clk          (clk),
    .rst_n        (rst_n),
    .armed        (core_run),
    .fetch_valid  (fetch_valid),
    .fetch_addr   (fetch_addr),
    .fetch_mapped (fetch_mapped),
    .rst_req      (rst_req)
  );
endmodule

// File: rtl/boot_guard_checker.sv
module boot_guard_checker #(
  parameter int unsigned RST_HOLD = 8
) (
  input logic        clk,
  input logic        rst_n,
  input logic        rd_req_valid,
  input logic        rd_req_ready,
  input logic [15:0] rd_addr,
  input logic        fetch_valid,
  input logic [15:0] fetch_addr,
  input logic        fetch_mapped,
  input logic        cpu_stall,
  input logic        core_run,
  input logic        core_sleep,
  input logic        rst_req,
  input logic        ldr_disable,
  input logic        bad_pw_erase_en
);
  p_stall_blocks_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_stall |-> (!core_run && !core_sleep));

  p_req_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_valid && !rd_req_ready) |=> (rd_req_valid && $stable(rd_addr)));

  p_one_mode_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_stall |-> (core_run != core_sleep));

  p_latched_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_stall |=> (!cpu_stall && $stable(core_run)));

  p_no_read_after_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_stall |-> !rd_req_valid);

  p_flags_fixed_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_stall |=> ($stable(ldr_disable) && $stable(bad_pw_erase_en)));

  p_off_key_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_stall && ldr_disable) |-> bad_pw_erase_en);

  p_periph_rst_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (core_run && fetch_valid && (fetch_addr <= 16'h01FF)) |=> rst_req);

  p_unmapped_rst_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (core_run && fetch_valid && !fetch_mapped) |=> rst_req);

  p_idle_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (!core_run && !rst_req) |=> !rst_req);
endmodule

bind boot_guard boot_guard_checker #(.RST_HOLD(RST_HOLD)) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .rd_req_valid    (rd_req_valid),
  .rd_req_ready    (rd_req_ready),
  .rd_addr         (rd_addr),
  .fetch_valid     (fetch_valid),
  .fetch_addr      (fetch_addr),
  .fetch_mapped    (fetch_mapped),
  .cpu_stall       (cpu_stall),
  .core_run        (core_run),
  .core_sleep      (core_sleep),
  .rst_req         (rst_req),
  .ldr_disable     (ldr_disable),
  .bad_pw_erase_en (bad_pw_erase_en)
);

// File: tb/boot_guard_test.sv
`timescale 1ns/1ps
module boot_guard_test;
  localparam int HOLD = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rd_req_valid;
  logic        rd_req_ready = 1'b0;
  logic [15:0] rd_addr;
  logic        rd_rsp_valid = 1'b0;
  logic [15:0] rd_rsp_data = 16'h0;
  logic        rd_rsp_ready;
  logic        fetch_valid = 1'b0;
  logic [15:0] fetch_addr = 16'h0;
  logic        fetch_mapped = 1'b0;
  logic        cpu_stall, core_run, core_sleep, rst_req, ldr_disable, bad_pw_erase_en;

  int checks = 0;
  int errors = 0;
  bit done_flag = 0;

  logic [15:0] mem_vec, mem_key;
  int stall_n = 0;
  int lat_n = 0;
  int nreq = 0;
  logic [15:0] seen0, seen1;

  always #2 clk = ~clk;

  boot_guard #(.RST_HOLD(HOLD)) uut (
    .clk(clk), .rst_n(rst_n),
    .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready), .rd_addr(rd_addr),
    .rd_rsp_valid(rd_rsp_valid), .rd_rsp_data(rd_rsp_data), .rd_rsp_ready(rd_rsp_ready),
    .fetch_valid(fetch_valid), .fetch_addr(fetch_addr), .fetch_mapped(fetch_mapped),
    .cpu_stall(cpu_stall), .core_run(core_run), .core_sleep(core_sleep),
    .rst_req(rst_req), .ldr_disable(ldr_disable), .bad_pw_erase_en(bad_pw_erase_en)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // memory responder: waits for a request, optionally withholds ready, answers once
  initial begin
    logic [15:0] a;
    forever begin
      @(negedge clk);
      if (rst_n && rd_req_valid) begin
        a = rd_addr;
        for (int s = 0; s < stall_n; s++) begin
          @(negedge clk);
          chk(rd_req_valid && rd_addr == a, "R2", "request held under back-pressure", int'(rd_addr), int'(a));
        end
        rd_req_ready = 1'b1;
        @(negedge clk);
        rd_req_ready = 1'b0;
        if (nreq == 0) seen0 = a;
        else if (nreq == 1) seen1 = a;
        nreq++;
        for (int l = 0; l < lat_n; l++) @(negedge clk);
        rd_rsp_valid = 1'b1;
        rd_rsp_data  = (a == 16'hFFFE) ? mem_vec : (a == 16'hFFDE) ? mem_key : 16'hDEAD;
        @(negedge clk);
        rd_rsp_valid = 1'b0;
      end
    end
  end

  task automatic run_boot(input logic [15:0] v, input logic [15:0] k, input int st, input int lt);
    int n;
    rst_n = 1'b0;
    mem_vec = v; mem_key = k; stall_n = st; lat_n = lt; nreq = 0;
    fetch_valid = 1'b0;
    repeat (3) @(negedge clk);
    #1 rst_n = 1'b1;
    fetch_valid = 1'b1; fetch_addr = 16'h0000; fetch_mapped = 1'b0;
    @(negedge clk);
    chk(cpu_stall == 1 && core_run == 0 && core_sleep == 0, "R1", "stalled after release",
        {cpu_stall, core_run, core_sleep}, 3'b100);
    chk(ldr_disable == 1 && bad_pw_erase_en == 0, "R1", "flags before key",
        {ldr_disable, bad_pw_erase_en}, 2'b10);
    chk(rd_req_valid == 1 && rd_addr == 16'hFFFE, "R1", "first request address",
        int'(rd_addr), 16'hFFFE);
    @(negedge clk);
    fetch_valid = 1'b0;
    @(negedge clk);
    chk(rst_req == 0, "R12", "fetch during stall ignored", rst_req, 0);
    n = 0;
    while (cpu_stall && n < 200) begin
      @(negedge clk);
      n++;
    end
    chk(nreq == 2 && seen0 == 16'hFFFE && seen1 == 16'hFFDE, "R2", "read order",
        int'(seen1), 16'hFFDE);
    if (v == 16'hFFFF)
      chk(core_sleep == 1 && core_run == 0, "R3", "blank vector sleeps", {core_run, core_sleep}, 2'b01);
    else
      chk(core_run == 1 && core_sleep == 0, "R3", "programmed vector runs", {core_run, core_sleep}, 2'b10);
    if (k == 16'hAA55)
      chk(ldr_disable == 1 && bad_pw_erase_en == 1, "R5", "loader off key",
          {ldr_disable, bad_pw_erase_en}, 2'b11);
    else if (k == 16'h0000)
      chk(ldr_disable == 0 && bad_pw_erase_en == 0, "R6", "erase block key",
          {ldr_disable, bad_pw_erase_en}, 2'b00);
    else
      chk(ldr_disable == 0 && bad_pw_erase_en == 1, "R7", "default key",
          {ldr_disable, bad_pw_erase_en}, 2'b01);
    repeat (4) @(negedge clk);
    chk(cpu_stall == 0 && rd_req_valid == 0 && nreq == 2, "R4", "decision held, no more reads",
        nreq, 2);
    chk((k == 16'hAA55) == ldr_disable, "R5", "flag still latched", ldr_disable, (k == 16'hAA55));
  endtask

  task automatic do_fetch(input logic [15:0] a, input logic m, input bit exp, input string req);
    int n;
    @(negedge clk);
    fetch_valid = 1'b1; fetch_addr = a; fetch_mapped = m;
    @(negedge clk);
    fetch_valid = 1'b0; fetch_mapped = 1'b0;
    chk(rst_req == exp, req, $sformatf("rst_req after fetch %04h map %0d", a, m), rst_req, exp);
    if (exp) begin
      n = 0;
      while (rst_req && n < 50) begin
        n++;
        @(negedge clk);
      end
      chk(n == HOLD, "R11", "reset request length", n, HOLD);
    end
  endtask

  initial begin
    logic [15:0] vecs [5];
    logic [15:0] keys [5];
    vecs = '{16'hFFFF, 16'hFFFE, 16'h7FFF, 16'h0000, 16'hC000};
    keys = '{16'hAA55, 16'h0000, 16'hAA54, 16'h55AA, 16'hFFFF};

    for (int i = 0; i < 5; i++)
      for (int j = 0; j < 5; j++)
        run_boot(vecs[i], keys[j], (i + j) % 3, (2 * i + j) % 4);

    // running core: fetch sweep across the address space
    run_boot(16'hC000, 16'h1234, 1, 1);
    for (int a = 0; a < 65536; a += 251) begin
      logic m;
      string tag;
      m = ((a / 251) % 3) != 0;
      tag = (a <= 16'h01FF) ? "R8" : (!m ? "R9" : "R10");
      do_fetch(16'(a), m, (a <= 16'h01FF) || !m, tag);
    end
    do_fetch(16'h01FF, 1'b1, 1'b1, "R8");
    do_fetch(16'h0000, 1'b1, 1'b1, "R8");
    do_fetch(16'h0200, 1'b1, 1'b0, "R10");
    do_fetch(16'h0200, 1'b0, 1'b1, "R9");
    do_fetch(16'hFFC0, 1'b1, 1'b0, "R10");
    do_fetch(16'hFFDC, 1'b1, 1'b0, "R10");
    do_fetch(16'hFFFE, 1'b1, 1'b0, "R10");

    // retrigger: second illegal fetch 3 cycles after the first reloads the count
    begin
      int n;
      @(negedge clk);
      fetch_valid = 1'b1; fetch_addr = 16'h0010; fetch_mapped = 1'b1;
      @(negedge clk);
      fetch_valid = 1'b0;
      repeat (2) @(negedge clk);
      fetch_valid = 1'b1; fetch_addr = 16'h0020;
      @(negedge clk);
      fetch_valid = 1'b0;
      n = 0;
      while (rst_req && n < 50) begin
        n++;
        @(negedge clk);
      end
      chk(n == HOLD, "R11", "reload length after retrigger", n, HOLD);
    end

    // sleeping core ignores fetches
    run_boot(16'hFFFF, 16'h5555, 0, 0);
    do_fetch(16'h0000, 1'b0, 1'b0, "R12");
    do_fetch(16'h8000, 1'b0, 1'b0, "R12");

    if (!done_flag) begin
      done_flag = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(4 * 150000);
    if (!done_flag) begin
      done_flag = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule